// File: doc/BRIEF.md
# Coherent 32-bit Read Pairing Over 16-bit Halves

This block sits between a 16-bit management access port and a bank of 32-bit registers. A host can only move 16 bits per access, so every 32-bit register value has to be read as two halves. The block makes that pair behave like one atomic 32-bit read. On the first half it captures the whole register, and the other half is then served from that capture. A value that changes between the two accesses, such as a rolling counter, can therefore never reach the host as a mix of old and new bits. Read side effects in the bank, such as clear-on-read, are released only by a one-cycle commit pulse. That pulse fires when a complete pair, or a single read of a register flagged as 16-bit readable, finishes.

Requests arrive on a valid/ready channel, and each accepted request returns one 16-bit response on a second valid/ready channel. The response stage holds a single entry. A new request is accepted only when that entry is empty, or when it is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_ready` is low, a pending response stays valid and its data does not change. The register bank is addressed combinationally through `bank_idx`. In the same cycle it returns the register contents and two attributes: the register may be read as a lone half, and the register is readable during reset. `rst_active` tells the block that the device is still in its reset phase.

Top module: `hwpair_top`

## Requirements
- R1: A pair is one access of each half of the same register index, in either order and back to back, with no accepted request in between. The response to each half carries that half's 16 bits: `req_hi`=1 selects bits 31:16 and `req_hi`=0 selects bits 15:0.
- R2: The second half of a pair is taken from the 32-bit value captured when the first half was accepted, even if the register changed in between.
- R3: A first half returns the live register value present in the cycle its request is accepted.
- R4: A request for the same index and the same half as the pending first half gives no commit. It discards the pending pair and becomes a new first half with a fresh capture.
- R5: A request for a different index than the pending first half abandons the old pair without a commit and becomes a new first half.
- R6: `commit_valid` is high for exactly one cycle per completed access. It rises in the same cycle that the response of the completing request becomes valid, and `commit_idx` carries that request's index.
- R7: A register flagged 16-bit readable returns its live half on a single access, commits at once and leaves no pair pending.
- R8: While `rst_active` is high, a register flagged reset-readable returns its live half and any other register returns zero. Neither case starts a pair or commits.
- R9: Any pending first half is discarded while `rst_active` is high, so after a reset ends between two halves, the next access is treated as a first half.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. A valid response with `rsp_ready` low keeps its data stable.
- R11: After `rst_n` is released, `rsp_valid` and `commit_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_idx | input | IDX_W | Register index |
| req_hi | input | 1 | 1 = bits 31:16, 0 = bits 15:0 |
| rsp_valid | output | 1 | Response data valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | HALF_W | 16-bit read data |
| bank_idx | output | IDX_W | Register index presented to the bank |
| bank_data | input | 2*HALF_W | Live 32-bit contents of bank_idx |
| bank_half_ok | input | 1 | bank_idx may be read as a lone half |
| bank_rst_ok | input | 1 | bank_idx is readable during reset |
| rst_active | input | 1 | Device reset phase in progress |
| commit_valid | output | 1 | One-cycle pulse: apply read side effects |
| commit_idx | output | IDX_W | Register index of the completed access |

## Verification
The assertions check several behaviours on every cycle. A matching second half yields a commit carrying its index, and a repeated half yields none. A cycle with `rst_active` high leaves no pending pair. Second-half data equals the captured half, and reads during reset of registers that are not reset-readable return zero. The commit always coincides with a valid response, and held responses stay stable. Other behaviours need the bench's scenarios and its cycle-by-cycle reference model. These are that a counter rolling between halves still yields the old coherent value, that abandoned pairs leave later pairs intact, and that back-pressure patterns never lose or duplicate a response.

// File: rtl/hwpair_pkg.sv
package hwpair_pkg;
  // What an accepted request does to the pairing state
  typedef enum logic [2:0] {
    ACT_NONE,    // no request accepted
    ACT_ZERO,    // reset phase, register not readable: return zero
    ACT_LIVE,    // reset phase, reset-readable register: live half, no pair
    ACT_SINGLE,  // 16-bit readable register: live half, commit now
    ACT_FIRST,   // opens a pair: capture full value
    ACT_SECOND   // completes a pair: serve captured half, commit
  } act_e;
endpackage

// File: rtl/hwpair_track.sv
module hwpair_track
  import hwpair_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             hi_i,
  input  logic             half_ok_i,
  input  logic             rst_ok_i,
  input  logic             rst_active_i,
  output act_e             act_o,
  output logic             commit_valid_o,
  output logic [IDX_W-1:0] commit_idx_o
);
  logic             pend_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic             pend_hi_q;
  logic             match_other;

  assign match_other = pend_q && (idx_i == pend_idx_q) && (hi_i != pend_hi_q);

  always_comb begin
    if (!acc_i)             act_o = ACT_NONE;
    else if (rst_active_i)  act_o = rst_ok_i ? ACT_LIVE : ACT_ZERO;
    else if (half_ok_i)     act_o = ACT_SINGLE;
    else if (match_other)   act_o = ACT_SECOND;
    else                    act_o = ACT_FIRST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      pend_hi_q  <= 1'b0;
    end else if (rst_active_i) begin
      pend_q <= 1'b0;
    end else begin
      unique case (act_o)
        ACT_FIRST: begin
          pend_q     <= 1'b1;
          pend_idx_q <= idx_i;
          pend_hi_q  <= hi_i;
        end
        ACT_SINGLE, ACT_SECOND: pend_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_valid_o <= 1'b0;
      commit_idx_o   <= '0;
    end else begin
      commit_valid_o <= (act_o == ACT_SINGLE) || (act_o == ACT_SECOND);
      if (acc_i) commit_idx_o <= idx_i;
    end
  end

  AST_RESET_DROPS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active_i |=> !pend_q); // R9

  AST_COMPLETE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !rst_active_i && !half_ok_i && pend_q && idx_i == pend_idx_q && hi_i != pend_hi_q)
    |=> (commit_valid_o && commit_idx_o == $past(idx_i))); // R6

  AST_REPEAT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !rst_active_i && !half_ok_i && pend_q && idx_i == pend_idx_q && hi_i == pend_hi_q)
    |=> (!commit_valid_o && pend_q && pend_hi_q == $past(hi_i))); // R4

  AST_NO_COMMIT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && rst_active_i) |=> !commit_valid_o); // R8
endmodule

// File: rtl/hwpair_snap.sv
module hwpair_snap #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout_o <= '0;
    else if (cap_i) dout_o <= din_i;
  end
endmodule

// File: rtl/hwpair_rsp.sv
module hwpair_rsp #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [HW-1:0] data_i,
  input  logic          rsp_ready_i,
  output logic          rsp_valid_o,
  output logic [HW-1:0] rsp_data_o,
  output logic          take_ready_o
);
  assign take_ready_o = !rsp_valid_o || rsp_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else if (load_i) begin
      rsp_valid_o <= 1'b1;
      rsp_data_o  <= data_i;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o))); // R10
endmodule

// File: rtl/hwpair_top.sv
module hwpair_top
  import hwpair_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [IDX_W-1:0]    req_idx,
  input  logic                req_hi,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [HALF_W-1:0]   rsp_data,
  output logic [IDX_W-1:0]    bank_idx,
  input  logic [2*HALF_W-1:0] bank_data,
  input  logic                bank_half_ok,
  input  logic                bank_rst_ok,
  input  logic                rst_active,
  output logic                commit_valid,
  output logic [IDX_W-1:0]    commit_idx
);
  localparam int FULL_W = 2 * HALF_W;

  act_e              act;
  logic              acc;
  logic [FULL_W-1:0] snap;
  logic [HALF_W-1:0] live_half, snap_half, out_half;

  assign acc      = req_valid && req_ready;
  assign bank_idx = req_idx;

  assign live_half = req_hi ? bank_data[FULL_W-1:HALF_W] : bank_data[HALF_W-1:0];
  assign snap_half = req_hi ? snap[FULL_W-1:HALF_W]      : snap[HALF_W-1:0];

  always_comb begin
    unique case (act)
      ACT_ZERO:   out_half = '0;
      ACT_SECOND: out_half = snap_half;
      default:    out_half = live_half;
    endcase
  end

  hwpair_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .idx_i(req_idx), .hi_i(req_hi),
    .half_ok_i(bank_half_ok), .rst_ok_i(bank_rst_ok), .rst_active_i(rst_active),
    .act_o(act), .commit_valid_o(commit_valid), .commit_idx_o(commit_idx)
  );

  hwpair_snap #(.DW(FULL_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .cap_i(act == ACT_FIRST), .din_i(bank_data), .dout_o(snap)
  );

  hwpair_rsp #(.HW(HALF_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load_i(acc), .data_i(out_half),
    .rsp_ready_i(rsp_ready), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .take_ready_o(req_ready)
  );

  AST_SECOND_FROM_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_SECOND) |=> (rsp_data == $past(snap_half))); // R2

  AST_ZERO_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rst_active && !bank_rst_ok) |=> (rsp_data == '0)); // R8

  AST_COMMIT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> rsp_valid); // R6
endmodule

// File: tb/hwpair_top_bench.sv
module hwpair_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;
  localparam int HALF_W = 16;
  localparam int NREG = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_hi = 1'b0, rsp_ready = 1'b1, rst_active = 1'b0;
  logic [IDX_W-1:0] req_idx = '0;
  logic req_ready, rsp_valid, commit_valid, bank_half_ok, bank_rst_ok;
  logic [HALF_W-1:0] rsp_data;
  logic [IDX_W-1:0] bank_idx, commit_idx;
  logic [2*HALF_W-1:0] bank_data;
  logic [31:0] bank [NREG];

  int checks = 0, fails = 0, cyc = 0;
  bit bp = 1'b0;
  string cur = "R11";

  // register 0 reset-readable, register 3 readable as a lone half
  assign bank_data    = bank[bank_idx];
  assign bank_rst_ok  = (bank_idx == 0);
  assign bank_half_ok = (bank_idx == 3);

  hwpair_top #(.IDX_W(IDX_W), .HALF_W(HALF_W)) u_hwpair_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_hi(req_hi), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .bank_idx(bank_idx), .bank_data(bank_data),
    .bank_half_ok(bank_half_ok), .bank_rst_ok(bank_rst_ok), .rst_active(rst_active),
    .commit_valid(commit_valid), .commit_idx(commit_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_valid = 0, m_commit = 0, m_pend = 0, m_phi = 0;
  logic [15:0] m_data = 0;
  int m_cidx = 0, m_pidx = 0;
  logic [31:0] m_snap = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_commit = 0; m_pend = 0;
    end else begin
      bit rdy, acc;
      logic [31:0] v;
      int i;
      rdy = !m_valid || rsp_ready;
      chk(cur, "req_ready", {31'd0, req_ready}, {31'd0, rdy});
      acc = req_valid && rdy;
      i = req_idx;
      v = bank[i];
      m_commit = 0;
      if (acc) begin
        m_valid = 1;
        m_cidx = i;
        if (rst_active) begin
          m_data = (i == 0) ? (req_hi ? v[31:16] : v[15:0]) : 16'h0;
        end else if (i == 3) begin
          m_data = req_hi ? v[31:16] : v[15:0];
          m_commit = 1; m_pend = 0;
        end else if (m_pend && m_pidx == i && m_phi != req_hi) begin
          m_data = req_hi ? m_snap[31:16] : m_snap[15:0];
          m_commit = 1; m_pend = 0;
        end else begin
          m_data = req_hi ? v[31:16] : v[15:0];
          m_snap = v; m_pend = 1; m_pidx = i; m_phi = req_hi;
        end
      end else if (rsp_ready) begin
        m_valid = 0;
      end
      if (rst_active) m_pend = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur, "rsp_valid", {31'd0, rsp_valid}, {31'd0, m_valid});
      if (m_valid) chk(cur, "rsp_data", {16'd0, rsp_data}, {16'd0, m_data});
      chk(cur, "commit_valid", {31'd0, commit_valid}, {31'd0, m_commit});
      if (m_commit) chk(cur, "commit_idx", {26'd0, commit_idx}, m_cidx);
    end
  end

  task automatic rd(int idx, bit hi);
    @(negedge clk);
    req_valid = 1; req_idx = idx[IDX_W-1:0]; req_hi = hi;
    rsp_ready = bp ? 1'($urandom % 2) : 1'b1;
    while (!req_ready) begin
      @(negedge clk);
      rsp_ready = bp ? 1'($urandom % 2) : 1'b1;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 0; rsp_ready = 1;
    end
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) bank[k] = 32'h1000_0000 + k * 32'h0001_0101;
    bank[1] = 32'hA5A5_1234;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R11", "commit_valid after reset", {31'd0, commit_valid}, 32'd0);

    cur = "R1"; rd(1, 0); rd(1, 1); rd(5, 1); rd(5, 0); idle(2);
    cur = "R3"; rd(7, 1); idle(1); bank[7] = 32'h7777_8888; rd(7, 0); idle(2);
    cur = "R2"; bank[1] = 32'h0001_FFFF; rd(1, 0);
    @(negedge clk); bank[1] = 32'h0002_0000; rd(1, 1); idle(2);
    chk("R2", "bank unchanged by capture", bank[1], 32'h0002_0000);
    cur = "R4"; rd(4, 0); bank[4] = 32'h4444_0001; rd(4, 0); bank[4] = 32'h4444_0002; rd(4, 1); idle(2);
    cur = "R5"; rd(4, 0); rd(5, 1); rd(4, 0); rd(4, 1); idle(2);
    cur = "R7"; rd(3, 0); rd(3, 1); rd(3, 1); idle(2);
    cur = "R6"; rd(6, 1); rd(6, 0); rd(2, 0); rd(2, 1); idle(2);
    cur = "R8"; @(negedge clk); rst_active = 1; rd(0, 1); rd(1, 0); rd(1, 1); rd(0, 0); idle(2);
    rst_active = 0; idle(1);
    cur = "R9"; rd(1, 0); idle(1); rst_active = 1; idle(1); rst_active = 0; rd(1, 1); rd(1, 0); idle(2);
    cur = "R10"; bp = 1;
    for (int n = 0; n < 60; n++) begin
      rd(n % 8, n[0] ^ n[3]);
      if (n % 5 == 0) bank[n % 8] = bank[n % 8] + 32'h0001_0001;
    end
    bp = 0; idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog %s actual=%0d expected=%0d", cur, cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule